// File: doc/BRIEF.md
# Composite Sync Separator and Blank Inserter

The block watches a horizontal sync line that may carry composite sync. It recovers the vertical interval hidden in that signal. The input is assumed to be already de-glitched and active high. The block measures the horizontal period in system clocks, from one leading edge to the next. Any pulse that stays high for more than half of that period is treated as part of a vertical interval.

A recognised interval sets a sticky presence flag. It also drives a recovered vertical sync output, delayed by a fixed number of clocks. The default of 96 clocks gives 8 µs at a 12 MHz clock. The flag drops again when no new interval has been seen for a configurable number of lines.

While the recovered vertical sync is high, the horizontal blank output can carry synthesised pulses. The serrated broad pulses are not passed through. Each synthesised pulse lasts one eighth of the held horizontal period and repeats at that period. A disable input turns this insertion off. Whenever insertion is not active, the blank output is the horizontal sync input delayed by one clock.

Top module: `csync_separator`

## Requirements
- R1: During and straight after reset, `cvsync_o`, `cv_present_o` and `hblank_o` are all 0.
- R2: A high pulse on `hsync_i` whose width exceeds half of the last measured period marks a vertical interval and sets `cv_present_o`. Pulses of 16 clocks on a 200-clock line never do. No interval is detected before a period has been measured.
- R3: `cvsync_o` is the vertical-interval indication delayed by DELAY_CYC clocks. The interval ends at the falling edge of the first pulse that never exceeded the half-period threshold.
- R4: The horizontal period is the number of clocks between consecutive rising edges of `hsync_i`. It is updated only outside a vertical interval and is held unchanged during one.
- R5: While `cvsync_o` is 1 and `ins_disable_i` is 0, `hblank_o` carries a pulse of floor(period/8) clocks once every period clocks. On a 200-clock line this is 25 high clocks per 200.
- R6: The insertion rate follows the measured period. After lines of 320 clocks, a 640-clock window contains exactly 80 high clocks.
- R7: While `ins_disable_i` is 1, or `cvsync_o` is 0, `hblank_o` equals `hsync_i` delayed by one clock.
- R8: `cv_present_o` clears on the TIMEOUT_LINES-th rising edge of `hsync_i` seen outside a vertical interval since the last interval. Any new interval restarts this count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Filtered horizontal (composite) sync, active high |
| ins_disable_i | input | 1 | 1 disables blank pulse insertion |
| cvsync_o | output | 1 | Recovered vertical sync, delayed |
| cv_present_o | output | 1 | Vertical sync recovered recently |
| hblank_o | output | 1 | Horizontal blank with optional inserted pulses |

## Verification
The hardest case to reach is insertion following a change of line length. The held period must first be re-learned from ordinary lines before broad pulses arrive. The bench therefore drives several narrow lines at 320 clocks after running at 200 clocks. It then starts a vertical interval and counts inserted high clocks over a window that sits wholly inside the recovered vertical sync. The presence timeout is reached by overriding the line limit to 32 and counting lines past the end of an interval.

// File: rtl/csync_pkg.sv
package csync_pkg;
    parameter int unsigned CSYNC_PER_W = 14;
    typedef logic [CSYNC_PER_W-1:0] period_t;
endpackage

// File: rtl/csync_period_meas.sv
module csync_period_meas
    import csync_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    hsync_i,
    input  logic    vint_i,
    output period_t period_o,
    output logic    rise_o,
    output logic    fall_o,
    output logic    broad_o
);
    typedef struct packed {
        logic    hs;
        logic    seen;
        period_t cnt;
        period_t wid;
        period_t per;
    } pm_t;

    pm_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        rise_o = hsync_i & ~st_q.hs;
        fall_o = ~hsync_i & st_q.hs;
        st_d.hs = hsync_i;
        if (rise_o) begin
            st_d.cnt  = period_t'(1);
            st_d.wid  = period_t'(1);
            st_d.seen = 1'b1;
            if (st_q.seen && !vint_i)
                st_d.per = st_q.cnt;
        end else begin
            if (st_q.cnt != '1)
                st_d.cnt = st_q.cnt + period_t'(1);
            if (hsync_i && st_q.wid != '1)
                st_d.wid = st_q.wid + period_t'(1);
        end
        broad_o  = st_q.hs && (st_q.per != '0) && (st_q.wid > (st_q.per >> 1));
        period_o = st_q.per;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: period is frozen while a vertical interval is flagged
    p_period_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vint_i |=> $stable(st_q.per));
endmodule

// File: rtl/csync_vdetect.sv
module csync_vdetect #(
    parameter int unsigned DELAY_CYC     = 96,
    parameter int unsigned TIMEOUT_LINES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic fall_i,
    input  logic broad_i,
    output logic vint_o,
    output logic cvsync_o,
    output logic present_o
);
    localparam int unsigned LINE_W = $clog2(TIMEOUT_LINES + 1);

    typedef struct packed {
        logic                 vint;
        logic                 bseen;
        logic                 present;
        logic [LINE_W-1:0]    lines;
        logic [DELAY_CYC-1:0] sr;
    } vd_t;

    vd_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rise_i)
            st_d.bseen = 1'b0;
        if (broad_i) begin
            st_d.vint  = 1'b1;
            st_d.bseen = 1'b1;
        end else if (fall_i && !st_q.bseen) begin
            st_d.vint = 1'b0;
        end
        st_d.sr = {st_q.sr[DELAY_CYC-2:0], st_q.vint};
        if (st_d.vint && !st_q.vint)
            st_d.present = 1'b1;
        if (st_q.vint) begin
            st_d.lines = '0;
        end else if (rise_i) begin
            if (st_q.lines == LINE_W'(TIMEOUT_LINES - 1))
                st_d.present = 1'b0;
            else
                st_d.lines = st_q.lines + LINE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vint_o    = st_q.vint;
    assign cvsync_o  = st_q.sr[DELAY_CYC-1];
    assign present_o = st_q.present;

    // R2: an interval only begins on a pulse judged broad by the period logic
    p_vint_needs_broad_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.vint) |-> $past(broad_i));
    // R8: the flag never drops inside a vertical interval
    p_present_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.present) |-> !st_q.vint);
endmodule

// File: rtl/csync_blank_ins.sv
module csync_blank_ins
    import csync_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    hsync_i,
    input  logic    cvs_i,
    input  logic    dis_i,
    input  period_t period_i,
    output logic    hblank_o
);
    typedef struct packed {
        period_t phase;
        logic    hb;
    } bi_t;

    bi_t     st_d, st_q;
    logic    ins_on;
    period_t nxt;

    always_comb begin
        st_d   = st_q;
        ins_on = cvs_i & ~dis_i;
        nxt    = st_q.phase + period_t'(1);
        if (!cvs_i)
            st_d.phase = '0;
        else if (nxt >= period_i)
            st_d.phase = '0;
        else
            st_d.phase = nxt;
        st_d.hb = ins_on ? (st_q.phase < (period_i >> 3)) : hsync_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hblank_o = st_q.hb;

    // R7: without insertion the blank output follows the sync input by one clock
    p_pass_through_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_on |=> (st_q.hb == $past(hsync_i)));
endmodule

// File: rtl/csync_separator.sv
module csync_separator
    import csync_pkg::*;
#(
    parameter int unsigned DELAY_CYC     = 96,
    parameter int unsigned TIMEOUT_LINES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_i,
    input  logic ins_disable_i,
    output logic cvsync_o,
    output logic cv_present_o,
    output logic hblank_o
);
    period_t period;
    logic    rise, fall, broad, vint;

    csync_period_meas u_period (
        .clk      (clk),
        .rst_n    (rst_n),
        .hsync_i  (hsync_i),
        .vint_i   (vint),
        .period_o (period),
        .rise_o   (rise),
        .fall_o   (fall),
        .broad_o  (broad)
    );

    csync_vdetect #(
        .DELAY_CYC     (DELAY_CYC),
        .TIMEOUT_LINES (TIMEOUT_LINES)
    ) u_vdet (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (rise),
        .fall_i    (fall),
        .broad_i   (broad),
        .vint_o    (vint),
        .cvsync_o  (cvsync_o),
        .present_o (cv_present_o)
    );

    csync_blank_ins u_blank (
        .clk      (clk),
        .rst_n    (rst_n),
        .hsync_i  (hsync_i),
        .cvs_i    (cvsync_o),
        .dis_i    (ins_disable_i),
        .period_i (period),
        .hblank_o (hblank_o)
    );

    // R2: recovered vertical sync only appears while the presence flag is up
    p_cvs_implies_present_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cvsync_o |-> cv_present_o);
    // R1: outputs quiet in the first cycle out of reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!cvsync_o && !cv_present_o));
endmodule

// File: tb/csync_separator_tb_top.sv
`timescale 1ns/1ps
module csync_separator_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs = 1'b0;
    logic dis = 1'b0;
    logic cvsync_o, cv_present_o, hblank_o;

    int n_chk = 0;
    int n_err = 0;
    int vcyc = 0;
    int ws = 0;
    int we = 0;
    int hb_cnt = 0;
    int pass_err = 0;
    bit ins_mon = 0;
    bit pass_mon = 0;
    logic v150, v250;

    always #10 clk = ~clk;

    csync_separator #(.DELAY_CYC(96), .TIMEOUT_LINES(32)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .hsync_i       (hs),
        .ins_disable_i (dis),
        .cvsync_o      (cvsync_o),
        .cv_present_o  (cv_present_o),
        .hblank_o      (hblank_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic v);
        @(negedge clk);
        vcyc++;
        if (pass_mon && hblank_o !== hs) pass_err++;
        if (ins_mon && vcyc >= ws && vcyc < we) hb_cnt += int'(hblank_o);
        if (vcyc == 150) v150 = cvsync_o;
        if (vcyc == 250) v250 = cvsync_o;
        hs = v;
    endtask

    task automatic line(input int per, input int hi);
        for (int i = 0; i < per; i++) tick(i < hi);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1 cvsync in reset", int'(cvsync_o), 0);
        chk("R1 present in reset", int'(cv_present_o), 0);
        chk("R1 hblank in reset", int'(hblank_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 present after reset", int'(cv_present_o), 0);
    endtask

    task automatic t_normal;
        pass_err = 0; pass_mon = 1;
        for (int l = 0; l < 10; l++) line(200, 16);
        pass_mon = 0;
        chk("R7 passthrough on normal lines", pass_err, 0);
        chk("R2 no detection on narrow pulses", int'(cv_present_o), 0);
        chk("R2 no cvsync on narrow pulses", int'(cvsync_o), 0);
    endtask

    task automatic t_vert_on;
        for (int l = 0; l < 4; l++) line(200, 16);
        vcyc = 0; ws = 300; we = 700; hb_cnt = 0; ins_mon = 1;
        for (int l = 0; l < 6; l++) line(200, 170);
        ins_mon = 0;
        chk("R3 cvsync still low before delay", int'(v150), 0);
        chk("R3 cvsync high after delay", int'(v250), 1);
        chk("R5 inserted high clocks in 400", hb_cnt, 50);
        chk("R2 present after broad pulses", int'(cv_present_o), 1);
        for (int l = 0; l < 3; l++) line(200, 16);
        chk("R3 cvsync ends after narrow pulse", int'(cvsync_o), 0);
        chk("R2 present held after interval", int'(cv_present_o), 1);
    endtask

    task automatic t_vert_320;
        for (int l = 0; l < 4; l++) line(320, 24);
        vcyc = 0; ws = 300; we = 940; hb_cnt = 0; ins_mon = 1;
        for (int l = 0; l < 6; l++) line(320, 280);
        ins_mon = 0;
        chk("R6 R4 inserted high clocks in 640", hb_cnt, 80);
        for (int l = 0; l < 3; l++) line(320, 24);
        chk("R3 cvsync ends at 320", int'(cvsync_o), 0);
        pass_err = 0; pass_mon = 1;
        for (int l = 0; l < 4; l++) line(200, 16);
        pass_mon = 0;
        chk("R7 passthrough after interval", pass_err, 0);
    endtask

    task automatic t_disabled;
        dis = 1'b1;
        for (int l = 0; l < 2; l++) line(200, 16);
        vcyc = 0; pass_err = 0; pass_mon = 1;
        for (int l = 0; l < 6; l++) line(200, 170);
        pass_mon = 0;
        chk("R7 disabled passes broad pulses", pass_err, 0);
        chk("R3 cvsync active while disabled", int'(v250), 1);
        for (int l = 0; l < 3; l++) line(200, 16);
        dis = 1'b0;
    endtask

    task automatic t_timeout;
        for (int l = 0; l < 6; l++) line(200, 170);
        for (int l = 0; l < 30; l++) line(200, 16);
        chk("R8 present kept before limit", int'(cv_present_o), 1);
        for (int l = 0; l < 4; l++) line(200, 16);
        chk("R8 present cleared after limit", int'(cv_present_o), 0);
        chk("R8 cvsync low after timeout", int'(cvsync_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset;
        t_normal;
        t_vert_on;
        t_vert_320;
        t_disabled;
        t_timeout;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule